// File: doc/BRIEF.md
# Faulting Instruction Capture Unit

This block holds the exception-capture state of a 32-bit processor's system-control coprocessor. When the pipeline raises an exception, it supplies a 5-bit exception code together with the context of the fault: the PC, the faulting instruction word, and the word before it. It also says whether the fault came from instruction fetch, whether the instruction sits in a branch delay slot, and whether the core runs in its compressed instruction mode. From these the unit records the resume PC and the exception code. It sets or clears the branch-delay flag and, for some exceptions, saves copies of the faulting instruction and of the branch that precedes it.

Capture is selective. The resume PC, the delay flag and the saved instruction words are written only when the core is not already at exception level. The instruction words are saved only for exception classes that have a valid instruction word, and only while two configuration enables allow it. The unit keeps the exception-level flag itself: any exception sets it, and a return-from-exception pulse clears it. Software reads every captured value through a register/select read port.

Top module: `fault_capture_unit`

## Requirements
- R1: After a synchronous active-high reset, every readable register and the exception-level flag are zero.
- R2: On an exception taken with the exception-level flag clear, the resume PC register is loaded with PC-4 when the fault is in a delay slot and with PC otherwise.
- R3: Every exception writes its code into cause bits 6:2. The branch-delay flag in cause bit 31 is set or cleared from the delay-slot input only when the exception-level flag was clear.
- R4: An exception with code 11 loads cause bits 29:28 from the coprocessor-number input. Other codes leave those bits unchanged.
- R5: Any exception sets the exception-level flag on the next edge. A return pulse without an exception clears it, and an exception in the same cycle as a return wins.
- R6: The faulting-word register is written only when the word enable is set. The prior-branch register is written with the supplied preceding word only when the prior enable is set and the fault is in a delay slot.
- R7: Codes 3, 5, 8, 9, 10, 11, 12, 13, 15 and 19 are eligible to update the saved instruction words.
- R8: Codes 1, 2 and 4 are eligible only when the fault did not arise during instruction fetch.
- R9: All other codes, including 6, 18, 20 and 0, leave both saved instruction words unchanged.
- R10: While the compressed-mode input is high, an exception leaves both saved instruction words unchanged. The resume PC and the cause register are still updated.
- R11: An exception taken while the exception-level flag is set leaves the resume PC, the branch-delay flag and both saved instruction words unchanged.
- R12: The read port is combinational and maps the following registers; every other register/select pair reads zero:
  - register 8 select 1: faulting word
  - register 8 select 2: prior-branch word
  - register 12 select 0: status, with the exception-level flag in bit 1
  - register 13 select 0: cause
  - register 14 select 0: resume PC

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception strobe, one cycle |
| exc_code | input | 5 | Exception code |
| exc_ifetch | input | 1 | Fault arose during instruction fetch |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| exc_compact | input | 1 | Core is in compressed instruction mode |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_word | input | 32 | Faulting instruction word |
| exc_prev_word | input | 32 | Instruction word at PC-4 |
| exc_cop_num | input | 2 | Coprocessor number for code 11 |
| cfg_word_en | input | 1 | Enables saving the faulting word |
| cfg_prev_en | input | 1 | Enables saving the prior-branch word |
| ret_pulse | input | 1 | Return from exception, clears the exception level |
| exc_level | output | 1 | Exception-level flag |
| rd_reg | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data |

## Verification
On every cycle, the assertions check these rules:
- exception level blocks capture of the resume PC and the saved words;
- compressed mode and the never-eligible codes 6, 18 and 20 leave the saved words untouched;
- the branch-delay flag follows the delay input on a taken exception;
- the exception-level flag is set after every exception and cleared after a lone return.

Only the bench's scenarios can show that the fetch-sourced codes 1, 2 and 4 are gated correctly, and that each configuration enable acts on its own register. They also show the coprocessor-number field sticking across later codes, the priority of an exception over a simultaneous return, and the read port's mapping, including unmapped addresses.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
    localparam int DATA_W     = 32;
    localparam int CODE_W     = 5;
    localparam int REGN_W     = 5;
    localparam int SEL_W      = 3;
    localparam int COPN_W     = 2;
    localparam int INSN_BYTES = 4;

    localparam logic [REGN_W-1:0] RN_BADINSN = 5'd8;
    localparam logic [REGN_W-1:0] RN_STATUS  = 5'd12;
    localparam logic [REGN_W-1:0] RN_CAUSE   = 5'd13;
    localparam logic [REGN_W-1:0] RN_RESUME  = 5'd14;
    localparam logic [SEL_W-1:0]  SEL_WORD   = 3'd1;
    localparam logic [SEL_W-1:0]  SEL_PREV   = 3'd2;

    localparam logic [CODE_W-1:0] CODE_COP_UNUSABLE = 5'd11;

    typedef struct packed {
        logic              bd;
        logic              rsv_hi;
        logic [COPN_W-1:0] cop;
        logic [20:0]       rsv_mid;
        logic [CODE_W-1:0] code;
        logic [1:0]        rsv_lo;
    } cause_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic              ifetch;
        logic              in_delay;
        logic              compact;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] prev_word;
        logic [COPN_W-1:0] cop;
    } exc_req_t;

    // Whether an exception class carries a usable instruction word.
    function automatic logic word_eligible(input logic [CODE_W-1:0] code,
                                           input logic ifetch);
        case (code)
            5'd3, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11,
            5'd12, 5'd13, 5'd15, 5'd19:   return 1'b1;
            5'd1, 5'd2, 5'd4:             return !ifetch;
            default:                      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/fcu_policy.sv
module fcu_policy
    import fcu_pkg::*;
(
    input  exc_req_t          req,
    input  logic              level_now,
    input  logic              word_en,
    input  logic              prev_en,
    output logic              take,
    output logic              word_we,
    output logic              prev_we,
    output logic [DATA_W-1:0] resume_pc
);
    logic eligible;

    always_comb begin
        take      = req.valid && !level_now;
        eligible  = take && !req.compact && word_eligible(req.code, req.ifetch);
        word_we   = eligible && word_en;
        prev_we   = eligible && prev_en && req.in_delay;
        resume_pc = req.in_delay ? (req.pc - DATA_W'(INSN_BYTES)) : req.pc;
    end
endmodule

// File: rtl/fcu_state.sv
module fcu_state
    import fcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  exc_req_t          req,
    input  logic              take,
    input  logic              word_we,
    input  logic              prev_we,
    input  logic [DATA_W-1:0] resume_pc,
    input  logic              ret_pulse,
    output logic [DATA_W-1:0] resume_q,
    output cause_t            cause_q,
    output logic [DATA_W-1:0] word_q,
    output logic [DATA_W-1:0] prev_q,
    output logic              level_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resume_q <= '0;
            cause_q  <= '0;
            word_q   <= '0;
            prev_q   <= '0;
            level_q  <= 1'b0;
        end else begin
            if (req.valid) begin
                cause_q.code <= req.code;
                if (req.code == CODE_COP_UNUSABLE)
                    cause_q.cop <= req.cop;
                level_q <= 1'b1;
            end else if (ret_pulse) begin
                level_q <= 1'b0;
            end
            if (take) begin
                resume_q   <= resume_pc;
                cause_q.bd <= req.in_delay;
            end
            if (word_we) word_q <= req.word;
            if (prev_we) prev_q <= req.prev_word;
        end
    end

    // R11
    held_at_level_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && level_q) |=> ($stable(resume_q) && $stable(word_q) &&
                                    $stable(prev_q) && $stable(cause_q.bd)));
    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> level_q);
    // R5
    level_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_pulse && !req.valid) |=> !level_q);
endmodule

// File: rtl/fcu_readmux.sv
module fcu_readmux
    import fcu_pkg::*;
(
    input  logic [REGN_W-1:0] rd_reg,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [DATA_W-1:0] resume_q,
    input  cause_t            cause_q,
    input  logic [DATA_W-1:0] word_q,
    input  logic [DATA_W-1:0] prev_q,
    input  logic              level_q,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        case (rd_reg)
            RN_BADINSN: begin
                if (rd_sel == SEL_WORD)      rd_data = word_q;
                else if (rd_sel == SEL_PREV) rd_data = prev_q;
            end
            RN_STATUS: if (rd_sel == '0) rd_data = {{(DATA_W-2){1'b0}}, level_q, 1'b0};
            RN_CAUSE:  if (rd_sel == '0) rd_data = cause_q;
            RN_RESUME: if (rd_sel == '0) rd_data = resume_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit
    import fcu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_valid,
    input  logic [4:0]  exc_code,
    input  logic        exc_ifetch,
    input  logic        exc_in_delay,
    input  logic        exc_compact,
    input  logic [31:0] exc_pc,
    input  logic [31:0] exc_word,
    input  logic [31:0] exc_prev_word,
    input  logic [1:0]  exc_cop_num,
    input  logic        cfg_word_en,
    input  logic        cfg_prev_en,
    input  logic        ret_pulse,
    output logic        exc_level,
    input  logic [4:0]  rd_reg,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data
);
    exc_req_t          req;
    logic              take, word_we, prev_we;
    logic [DATA_W-1:0] resume_pc, resume_q, word_q, prev_q;
    cause_t            cause_q;
    logic              level_q;

    always_comb begin
        req.valid     = exc_valid;
        req.code      = exc_code;
        req.ifetch    = exc_ifetch;
        req.in_delay  = exc_in_delay;
        req.compact   = exc_compact;
        req.pc        = exc_pc;
        req.word      = exc_word;
        req.prev_word = exc_prev_word;
        req.cop       = exc_cop_num;
    end

    fcu_policy u_policy (
        .req(req), .level_now(level_q), .word_en(cfg_word_en),
        .prev_en(cfg_prev_en), .take(take), .word_we(word_we),
        .prev_we(prev_we), .resume_pc(resume_pc)
    );

    fcu_state u_state (
        .clk(clk), .rst(rst), .req(req), .take(take), .word_we(word_we),
        .prev_we(prev_we), .resume_pc(resume_pc), .ret_pulse(ret_pulse),
        .resume_q(resume_q), .cause_q(cause_q), .word_q(word_q),
        .prev_q(prev_q), .level_q(level_q)
    );

    fcu_readmux u_readmux (
        .rd_reg(rd_reg), .rd_sel(rd_sel), .resume_q(resume_q),
        .cause_q(cause_q), .word_q(word_q), .prev_q(prev_q),
        .level_q(level_q), .rd_data(rd_data)
    );

    assign exc_level = level_q;

    // R10
    compact_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_compact) |=> ($stable(word_q) && $stable(prev_q)));
    // R9
    never_code_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && (exc_code == 5'd6 || exc_code == 5'd18 || exc_code == 5'd20))
        |=> ($stable(word_q) && $stable(prev_q)));
    // R3
    delay_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !level_q) |=> (cause_q.bd == $past(exc_in_delay)));
    // R2
    resume_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !level_q && !exc_in_delay) |=> (resume_q == $past(exc_pc)));
endmodule

// File: tb/fault_capture_unit_tb.sv
module fault_capture_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_ifetch = 1'b0, exc_in_delay = 1'b0, exc_compact = 1'b0;
    logic [31:0] exc_pc = '0, exc_word = '0, exc_prev_word = '0;
    logic [1:0]  exc_cop_num = '0;
    logic        cfg_word_en = 1'b1, cfg_prev_en = 1'b1, ret_pulse = 1'b0;
    logic        exc_level;
    logic [4:0]  rd_reg = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] m_resume = '0, m_cause = '0, m_word = '0, m_prev = '0;
    logic        m_level = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_capture_unit u_dut (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_ifetch(exc_ifetch), .exc_in_delay(exc_in_delay),
        .exc_compact(exc_compact), .exc_pc(exc_pc), .exc_word(exc_word),
        .exc_prev_word(exc_prev_word), .exc_cop_num(exc_cop_num),
        .cfg_word_en(cfg_word_en), .cfg_prev_en(cfg_prev_en),
        .ret_pulse(ret_pulse), .exc_level(exc_level), .rd_reg(rd_reg),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // exception-level output compared on every clock (R5)
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            vectors++;
            if (exc_level !== m_level) begin
                miscompares++;
                $display("FAIL R5 level: got %0b expected %0b", exc_level, m_level);
            end
        end
    end

    function automatic bit model_has_word(input logic [4:0] c, input logic f);
        int always_set[$] = '{3, 5, 8, 9, 10, 11, 12, 13, 15, 19};
        int fetch_set[$]  = '{1, 2, 4};
        foreach (always_set[i]) if (always_set[i] == int'(c)) return 1'b1;
        foreach (fetch_set[i])  if (fetch_set[i] == int'(c)) return !f;
        return 1'b0;
    endfunction

    task automatic raise(input logic [4:0] c, input logic f, input logic d,
                         input logic cm, input logic [31:0] pc,
                         input logic [31:0] w, input logic [31:0] pw,
                         input logic [1:0] cn, input logic rt);
        @(negedge clk);
        exc_valid = 1'b1; exc_code = c; exc_ifetch = f; exc_in_delay = d;
        exc_compact = cm; exc_pc = pc; exc_word = w; exc_prev_word = pw;
        exc_cop_num = cn; ret_pulse = rt;
        m_cause[6:2] = c;
        if (c == 5'd11) m_cause[29:28] = cn;
        if (!m_level) begin
            m_resume = d ? pc - 32'd4 : pc;
            m_cause[31] = d;
            if (!cm && model_has_word(c, f)) begin
                if (cfg_word_en) m_word = w;
                if (cfg_prev_en && d) m_prev = pw;
            end
        end
        m_level = 1'b1;
        @(posedge clk);
        #1 exc_valid = 1'b0; ret_pulse = 1'b0;
    endtask

    task automatic leave();
        @(negedge clk);
        ret_pulse = 1'b1;
        m_level = 1'b0;
        @(posedge clk);
        #1 ret_pulse = 1'b0;
    endtask

    task automatic check_rd(input logic [4:0] r, input logic [2:0] s,
                            input logic [31:0] exp, input string tag);
        rd_reg = r; rd_sel = s;
        #1;
        vectors++;
        if (rd_data !== exp) begin
            miscompares++;
            $display("FAIL %s reg %0d sel %0d: got %h expected %h", tag, r, s, rd_data, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        check_rd(5'd8,  3'd1, m_word,   tag);
        check_rd(5'd8,  3'd2, m_prev,   tag);
        check_rd(5'd12, 3'd0, {30'd0, m_level, 1'b0}, tag);
        check_rd(5'd13, 3'd0, m_cause,  tag);
        check_rd(5'd14, 3'd0, m_resume, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_all("R1 reset");
        // R12 unmapped addresses read zero
        check_rd(5'd8,  3'd0, 32'd0, "R12 unmapped");
        check_rd(5'd13, 3'd1, 32'd0, "R12 unmapped");
        check_rd(5'd3,  3'd0, 32'd0, "R12 unmapped");

        // R2 R7 plain syscall
        raise(5'd8, 0, 0, 0, 32'h1000, 32'hAAAA0001, 32'hBBBB0001, 2'd0, 0);
        check_all("R2 R7 syscall");
        leave();
        // R2 R6 delay slot with prior word
        raise(5'd10, 0, 1, 0, 32'h2004, 32'hAAAA0002, 32'hBBBB0002, 2'd0, 0);
        check_all("R2 R6 delay slot");
        // R11 second exception at level: only code changes
        raise(5'd13, 0, 0, 0, 32'h3000, 32'hAAAA0003, 32'hBBBB0003, 2'd0, 0);
        check_all("R11 nested");
        leave();
        check_all("R5 return");
        // R8 fetch-sourced codes
        raise(5'd2, 1, 0, 0, 32'h4000, 32'hAAAA0004, 32'h0, 2'd0, 0);
        check_all("R8 code2 fetch");
        leave();
        raise(5'd2, 0, 0, 0, 32'h4100, 32'hAAAA0005, 32'h0, 2'd0, 0);
        check_all("R8 code2 data");
        leave();
        raise(5'd4, 1, 1, 0, 32'h4204, 32'hAAAA0006, 32'hBBBB0006, 2'd0, 0);
        check_all("R8 code4 fetch");
        leave();
        raise(5'd1, 0, 1, 0, 32'h4304, 32'hAAAA0007, 32'hBBBB0007, 2'd0, 0);
        check_all("R8 code1 data");
        leave();
        // R9 never-eligible codes
        raise(5'd6, 0, 1, 0, 32'h5004, 32'hAAAA0008, 32'hBBBB0008, 2'd0, 0);
        check_all("R9 code6");
        leave();
        raise(5'd18, 0, 0, 0, 32'h5100, 32'hAAAA0009, 32'h0, 2'd0, 0);
        check_all("R9 code18");
        leave();
        raise(5'd20, 0, 1, 0, 32'h5204, 32'hAAAA000A, 32'hBBBB000A, 2'd0, 0);
        check_all("R9 code20");
        leave();
        raise(5'd0, 0, 0, 0, 32'h5300, 32'hAAAA000B, 32'h0, 2'd0, 0);
        check_all("R9 code0");
        leave();
        // R4 coprocessor number field
        raise(5'd11, 0, 0, 0, 32'h6000, 32'hAAAA000C, 32'h0, 2'd2, 0);
        check_all("R4 cop unusable");
        leave();
        raise(5'd12, 0, 0, 0, 32'h6100, 32'hAAAA000D, 32'h0, 2'd3, 0);
        check_all("R4 cop kept");
        leave();
        // R10 compressed mode
        raise(5'd9, 0, 1, 1, 32'h7004, 32'hAAAA000E, 32'hBBBB000E, 2'd0, 0);
        check_all("R10 compact");
        leave();
        // R6 enables acting separately
        cfg_word_en = 1'b0;
        raise(5'd3, 0, 1, 0, 32'h8004, 32'hAAAA000F, 32'hBBBB000F, 2'd0, 0);
        check_all("R6 word disabled");
        leave();
        cfg_word_en = 1'b1; cfg_prev_en = 1'b0;
        raise(5'd19, 0, 1, 0, 32'h8104, 32'hAAAA0010, 32'hBBBB0010, 2'd0, 0);
        check_all("R6 prev disabled");
        leave();
        cfg_prev_en = 1'b1;
        // R7 remaining codes
        raise(5'd15, 0, 0, 0, 32'h9000, 32'hAAAA0011, 32'h0, 2'd0, 0);
        check_all("R7 code15");
        leave();
        raise(5'd5, 1, 1, 0, 32'h9104, 32'hAAAA0012, 32'hBBBB0012, 2'd0, 0);
        check_all("R7 code5");
        // R5 exception together with return: level stays set
        leave();
        raise(5'd8, 0, 0, 0, 32'hA000, 32'hAAAA0013, 32'h0, 2'd0, 1);
        check_all("R5 exc beats return");
        leave();
        check_all("R5 final");

        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule